// File: doc/BRIEF.md
# Conditional Branch and Skip Resolver

This block decides where a small processor core's program counter goes after a conditional control-flow instruction. The decoder hands it one request per cycle. Each request carries:

- the current PC and the status register;
- a decoded kind code;
- a status-bit selector and a signed 7-bit displacement;
- a data byte with a bit index;
- two compare operands;
- a flag saying whether the instruction after this one is two words long.

The block registers its decision, which is a next PC and a taken/skip indication. The result appears one clock after the request.

There are two families of instructions. Relative branches test a status bit, the signed-order relation N xor V, or the carry bit, and jump to PC + 1 + displacement. Skips test operand equality or a single bit of a register or I/O byte, and step over the following instruction. A skip lands at PC + 2 or PC + 3, depending on the length of the following instruction. The block never alters status flags.

Top module: `bsr_resolver`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, out_valid, taken and next_pc are all 0.
- R2: A request presented with req_valid high at a rising edge produces out_valid high, with its taken and next_pc, right after that edge. A cycle with req_valid low produces out_valid low right after the edge.
- R3: Kind 0 is the set-form branch and is taken when sreg[flag_sel] is 1. Kind 1 is the clear-form branch and is taken when sreg[flag_sel] is 0.
- R4: Kind 2 is the signed greater-or-equal branch and is taken when sreg[2] xor sreg[3] is 0. Kind 3 is the signed less-than branch and is taken when that xor is 1.
- R5: Kind 4 is the same-or-higher branch and is taken when sreg[0] is 0. Kind 5 is the lower branch and is taken when sreg[0] is 1.
- R6: A taken branch gives next_pc = pc_in + 1 + sign-extended disp, modulo 2^PC_W. A branch that is not taken gives pc_in + 1.
- R7: Kind 8 skips when op_a equals op_b.
- R8: Kinds 9 and 11 skip when bit_val[bit_idx] is 0. Kinds 10 and 12 skip when bit_val[bit_idx] is 1. Kinds 9 and 10 test a register, and kinds 11 and 12 test an I/O byte.
- R9: A skip that occurs gives next_pc = pc_in + 3 when next_two_word is 1, and pc_in + 2 otherwise. A skip that does not occur gives pc_in + 1.
- R10: Kind codes 6, 7, 13, 14 and 15 are never taken and give next_pc = pc_in + 1.
- R11: While req_valid is low, next_pc and taken hold their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| pc_in | input | PC_W | PC of the instruction being resolved |
| sreg | input | SREG_W | Status register (C bit 0, Z bit 1, N bit 2, V bit 3) |
| kind | input | 4 | Decoded branch/skip kind code |
| flag_sel | input | clog2(SREG_W) | Status bit index for kinds 0 and 1 |
| disp | input | DISP_W | Two's-complement branch displacement |
| bit_val | input | DATA_W | Register or I/O byte under bit test |
| bit_idx | input | clog2(DATA_W) | Bit index into bit_val |
| op_a | input | DATA_W | First compare operand |
| op_b | input | DATA_W | Second compare operand |
| next_two_word | input | 1 | Following instruction is two words long |
| out_valid | output | 1 | Registered result valid |
| taken | output | 1 | Branch taken or skip performed |
| next_pc | output | PC_W | Resolved next PC |

## Verification
All three results of a request (out_valid, taken, next_pc) are due exactly one rising edge after the request is sampled. Nothing is spread over later cycles. The bench therefore drives each request on a falling edge and lets the next rising edge capture it. It compares all outputs on the following falling edge against a behavioural model evaluated from the same inputs. Idle cycles are compared the same way, against the values the model holds from the last request.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    // Decoded control-flow kinds; the code values are part of the interface.
    typedef enum logic [3:0] {
        K_BR_BITSET = 4'd0,
        K_BR_BITCLR = 4'd1,
        K_BR_SGE    = 4'd2,
        K_BR_SLT    = 4'd3,
        K_BR_HS     = 4'd4,
        K_BR_LO     = 4'd5,
        K_SK_EQ     = 4'd8,
        K_SK_RBCLR  = 4'd9,
        K_SK_RBSET  = 4'd10,
        K_SK_IOCLR  = 4'd11,
        K_SK_IOSET  = 4'd12
    } bsr_kind_e;

    // Status bit positions used by the fixed-condition branches.
    localparam int CARRY_POS = 0;
    localparam int NEG_POS   = 2;
    localparam int OVF_POS   = 3;

endpackage

// File: rtl/bsr_cond_eval.sv
module bsr_cond_eval
    import bsr_pkg::*;
#(
    parameter int SREG_W = 8,
    parameter int DATA_W = 8,
    localparam int FS_W  = $clog2(SREG_W),
    localparam int BI_W  = $clog2(DATA_W)
) (
    input  logic [3:0]        kind,
    input  logic [SREG_W-1:0] sreg,
    input  logic [FS_W-1:0]   flag_sel,
    input  logic [DATA_W-1:0] bit_val,
    input  logic [BI_W-1:0]   bit_idx,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              is_branch,
    output logic              is_skip,
    output logic              cond_met
);

    logic sel_flag;
    logic signed_lt;
    logic carry;
    logic tested_bit;
    logic ops_equal;

    always_comb begin
        sel_flag   = sreg[flag_sel];
        signed_lt  = sreg[NEG_POS] ^ sreg[OVF_POS];
        carry      = sreg[CARRY_POS];
        tested_bit = bit_val[bit_idx];
        ops_equal  = (op_a == op_b);
    end

    always_comb begin
        is_branch = 1'b0;
        is_skip   = 1'b0;
        cond_met  = 1'b0;
        case (kind)
            K_BR_BITSET: begin is_branch = 1'b1; cond_met = sel_flag;    end
            K_BR_BITCLR: begin is_branch = 1'b1; cond_met = !sel_flag;   end
            K_BR_SGE:    begin is_branch = 1'b1; cond_met = !signed_lt;  end
            K_BR_SLT:    begin is_branch = 1'b1; cond_met = signed_lt;   end
            K_BR_HS:     begin is_branch = 1'b1; cond_met = !carry;      end
            K_BR_LO:     begin is_branch = 1'b1; cond_met = carry;       end
            K_SK_EQ:     begin is_skip   = 1'b1; cond_met = ops_equal;   end
            K_SK_RBCLR,
            K_SK_IOCLR:  begin is_skip   = 1'b1; cond_met = !tested_bit; end
            K_SK_RBSET,
            K_SK_IOSET:  begin is_skip   = 1'b1; cond_met = tested_bit;  end
            default:     begin is_branch = 1'b0; is_skip = 1'b0; cond_met = 1'b0; end
        endcase
    end

endmodule

// File: rtl/bsr_target_calc.sv
module bsr_target_calc #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 7
) (
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DISP_W-1:0] disp,
    input  logic              next_two_word,
    output logic [PC_W-1:0]   seq_pc,
    output logic [PC_W-1:0]   branch_pc,
    output logic [PC_W-1:0]   skip_pc
);

    logic [PC_W-1:0] disp_ext;

    // Sign extension or truncation, picked by the relative widths.
    generate
        if (PC_W > DISP_W) begin : g_extend
            assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        seq_pc    = pc_in + PC_W'(1);
        branch_pc = seq_pc + disp_ext;
        skip_pc   = pc_in + (next_two_word ? PC_W'(3) : PC_W'(2));
    end

endmodule

// File: rtl/bsr_resolver.sv
module bsr_resolver
    import bsr_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DISP_W = 7,
    parameter int SREG_W = 8,
    parameter int DATA_W = 8,
    localparam int FS_W  = $clog2(SREG_W),
    localparam int BI_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [SREG_W-1:0] sreg,
    input  logic [3:0]        kind,
    input  logic [FS_W-1:0]   flag_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic [DATA_W-1:0] bit_val,
    input  logic [BI_W-1:0]   bit_idx,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              next_two_word,
    output logic              out_valid,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc
);

    typedef struct packed {
        logic            vld;
        logic            tk;
        logic [PC_W-1:0] pc;
    } res_t;

    res_t            res_d, res_q;
    logic            is_branch, is_skip, cond_met;
    logic [PC_W-1:0] seq_pc, branch_pc, skip_pc;

    bsr_cond_eval #(
        .SREG_W (SREG_W),
        .DATA_W (DATA_W)
    ) u_cond (
        .kind      (kind),
        .sreg      (sreg),
        .flag_sel  (flag_sel),
        .bit_val   (bit_val),
        .bit_idx   (bit_idx),
        .op_a      (op_a),
        .op_b      (op_b),
        .is_branch (is_branch),
        .is_skip   (is_skip),
        .cond_met  (cond_met)
    );

    bsr_target_calc #(
        .PC_W   (PC_W),
        .DISP_W (DISP_W)
    ) u_target (
        .pc_in         (pc_in),
        .disp          (disp),
        .next_two_word (next_two_word),
        .seq_pc        (seq_pc),
        .branch_pc     (branch_pc),
        .skip_pc       (skip_pc)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = req_valid;
        if (req_valid) begin
            res_d.tk = cond_met && (is_branch || is_skip);
            if (cond_met && is_branch)
                res_d.pc = branch_pc;
            else if (cond_met && is_skip)
                res_d.pc = skip_pc;
            else
                res_d.pc = seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign taken     = res_q.tk;
    assign next_pc   = res_q.pc;

endmodule

// File: rtl/bsr_resolver_chk.sv
module bsr_resolver_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [PC_W-1:0] pc_in,
    input logic [3:0]      kind,
    input logic            next_two_word,
    input logic            out_valid,
    input logic            taken,
    input logic [PC_W-1:0] next_pc
);

    // R2
    req_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(next_pc) && $stable(taken)));

    // R6
    not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (taken || next_pc == $past(pc_in) + PC_W'(1)));

    // R9
    skip_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind >= 4'd8 && kind <= 4'd12) |=>
        (!taken || next_pc == $past(pc_in) + ($past(next_two_word) ? PC_W'(3) : PC_W'(2))));

    // R10
    undefined_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (kind == 4'd6 || kind == 4'd7 || kind >= 4'd13)) |=> !taken);

endmodule

bind bsr_resolver bsr_resolver_chk #(.PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .pc_in         (pc_in),
    .kind          (kind),
    .next_two_word (next_two_word),
    .out_valid     (out_valid),
    .taken         (taken),
    .next_pc       (next_pc)
);

// File: tb/test_bsr_resolver.sv
module test_bsr_resolver;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [15:0] pc_in;
    logic [7:0]  sreg;
    logic [3:0]  kind;
    logic [2:0]  flag_sel;
    logic [6:0]  disp;
    logic [7:0]  bit_val;
    logic [2:0]  bit_idx;
    logic [7:0]  op_a, op_b;
    logic        next_two_word;
    logic        out_valid, taken;
    logic [15:0] next_pc;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    // Model state: expected outputs after the next edge.
    bit exp_vld = 0;
    bit exp_tk  = 0;
    int exp_pc  = 0;

    always #10 clk = ~clk;   // 50 MHz

    bsr_resolver i_bsr_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pc_in(pc_in),
        .sreg(sreg), .kind(kind), .flag_sel(flag_sel), .disp(disp),
        .bit_val(bit_val), .bit_idx(bit_idx), .op_a(op_a), .op_b(op_b),
        .next_two_word(next_two_word), .out_valid(out_valid),
        .taken(taken), .next_pc(next_pc)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung run, expected completion");
            summary();
        end
    end

    function automatic string tag_of(int k, bit tk);
        if (k <= 1) return "R3";
        if (k <= 3) return "R4";
        if (k <= 5) return "R5";
        if (k == 8) return "R7";
        if (k >= 9 && k <= 12) return tk ? "R9" : "R8";
        return "R10";
    endfunction

    // Behavioural reference.
    task automatic model(input int k, input int s, input int fs, input int d,
                         input int bv, input int bi, input int a, input int b,
                         input bit two, input int pc);
        bit c;
        int sd;
        bit br;
        c  = 0;
        br = (k <= 5);
        case (k)
            0: c = s[fs];
            1: c = !s[fs];
            2: c = (s[2] == s[3]);
            3: c = (s[2] != s[3]);
            4: c = !s[0];
            5: c = s[0];
            8: c = (a == b);
            9, 11: c = !bv[bi];
            10, 12: c = bv[bi];
            default: c = 0;
        endcase
        sd = (d >= 64) ? d - 128 : d;
        exp_vld = 1;
        exp_tk  = c;
        if (c && br)      exp_pc = (pc + 1 + sd) & 16'hFFFF;
        else if (c)       exp_pc = (pc + (two ? 3 : 2)) & 16'hFFFF;
        else              exp_pc = (pc + 1) & 16'hFFFF;
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (out_valid !== exp_vld || taken !== exp_tk || next_pc !== 16'(exp_pc)) begin
            n_fail++;
            $display("FAIL %s: actual vld=%0b tk=%0b pc=%h, expected vld=%0b tk=%0b pc=%h",
                     tag, out_valid, taken, next_pc, exp_vld, exp_tk, 16'(exp_pc));
        end
    endtask

    task automatic apply(input int k, input int s, input int fs, input int d,
                         input int bv, input int bi, input int a, input int b,
                         input bit two, input int pc, input string tag);
        req_valid = 1; kind = 4'(k); sreg = 8'(s); flag_sel = 3'(fs);
        disp = 7'(d); bit_val = 8'(bv); bit_idx = 3'(bi);
        op_a = 8'(a); op_b = 8'(b); next_two_word = two; pc_in = 16'(pc);
        model(k, s, fs, d, bv, bi, a, b, two, pc);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int junk);
        req_valid = 0; kind = 4'(junk); sreg = 8'(junk * 7);
        pc_in = 16'(junk * 331); op_a = 8'(junk); op_b = 8'(junk);
        next_two_word = junk[0];
        exp_vld = 0;
        @(negedge clk);
        compare("R11");
    endtask

    initial begin
        rst_n = 0; req_valid = 1; pc_in = 16'h1234; sreg = 8'hFF; kind = 0;
        flag_sel = 0; disp = 7'd5; bit_val = 0; bit_idx = 0;
        op_a = 0; op_b = 0; next_two_word = 0;
        repeat (3) @(negedge clk);
        exp_vld = 0; exp_tk = 0; exp_pc = 0;
        compare("R1");
        rst_n = 1; req_valid = 0;
        @(negedge clk);
        compare("R1");

        // R3 generic set/clear on several status bits
        apply(0, 8'h02, 1, 10, 0, 0, 0, 0, 0, 16'h0100, "R3");
        apply(0, 8'hFD, 1, 10, 0, 0, 0, 0, 0, 16'h0100, "R3");
        apply(1, 8'h40, 6, 3,  0, 0, 0, 0, 0, 16'h0200, "R3");
        apply(1, 8'hBF, 6, 3,  0, 0, 0, 0, 0, 16'h0200, "R3");
        // R4 signed order: N bit2, V bit3
        apply(2, 8'h0C, 0, 4, 0, 0, 0, 0, 0, 16'h0300, "R4");
        apply(2, 8'h04, 0, 4, 0, 0, 0, 0, 0, 16'h0300, "R4");
        apply(3, 8'h08, 0, 4, 0, 0, 0, 0, 0, 16'h0300, "R4");
        apply(3, 8'h00, 0, 4, 0, 0, 0, 0, 0, 16'h0300, "R4");
        // R5 carry tests
        apply(4, 8'h00, 0, 2, 0, 0, 0, 0, 0, 16'h0400, "R5");
        apply(4, 8'h01, 0, 2, 0, 0, 0, 0, 0, 16'h0400, "R5");
        apply(5, 8'h01, 0, 2, 0, 0, 0, 0, 0, 16'h0400, "R5");
        // R6 displacement extremes and wrap
        apply(0, 8'h01, 0, 64, 0, 0, 0, 0, 0, 16'h0010, "R6");
        apply(0, 8'h01, 0, 63, 0, 0, 0, 0, 0, 16'hFFF0, "R6");
        apply(0, 8'h01, 0, 127, 0, 0, 0, 0, 0, 16'h0000, "R6");
        // R7 compare-skip
        apply(8, 0, 0, 0, 0, 0, 8'hA5, 8'hA5, 0, 16'h0500, "R7");
        apply(8, 0, 0, 0, 0, 0, 8'hA5, 8'hA4, 1, 16'h0500, "R7");
        // R8 bit skips, register and I/O
        apply(9,  0, 0, 0, 8'hEF, 4, 0, 0, 0, 16'h0600, "R8");
        apply(10, 0, 0, 0, 8'h80, 7, 0, 0, 0, 16'h0600, "R8");
        apply(11, 0, 0, 0, 8'h01, 0, 0, 0, 1, 16'h0600, "R8");
        apply(12, 0, 0, 0, 8'h01, 0, 0, 0, 1, 16'h0600, "R8");
        // R9 two-word step and wrap
        apply(8, 0, 0, 0, 0, 0, 1, 1, 1, 16'hFFFE, "R9");
        apply(8, 0, 0, 0, 0, 0, 1, 1, 0, 16'hFFFF, "R9");
        // R10 undefined codes even with every condition looking true
        apply(6,  8'hFF, 0, 9, 8'hFF, 0, 3, 3, 1, 16'h0700, "R10");
        apply(7,  8'hFF, 0, 9, 8'hFF, 0, 3, 3, 1, 16'h0700, "R10");
        apply(13, 8'hFF, 0, 9, 8'hFF, 0, 3, 3, 1, 16'h0700, "R10");
        apply(15, 8'hFF, 0, 9, 8'hFF, 0, 3, 3, 1, 16'h0700, "R10");
        // R11 idle cycles hold, R2 restart afterwards
        apply(0, 8'h01, 0, 20, 0, 0, 0, 0, 0, 16'h0800, "R2");
        idle(5);
        idle(12);
        apply(1, 8'h01, 0, 20, 0, 0, 0, 0, 0, 16'h0900, "R2");

        for (int i = 0; i < 600; i++) begin
            int k, s, fs, d, bv, bi, a, b, pc;
            bit two;
            k = $urandom_range(0, 15); s = $urandom_range(0, 255);
            fs = $urandom_range(0, 7); d = $urandom_range(0, 127);
            bv = $urandom_range(0, 255); bi = $urandom_range(0, 7);
            a = $urandom_range(0, 3); b = $urandom_range(0, 3);
            two = 1'($urandom_range(0, 1)); pc = $urandom_range(0, 65535);
            if ($urandom_range(0, 7) == 0) idle(i);
            else begin
                model(k, s, fs, d, bv, bi, a, b, two, pc);
                apply(k, s, fs, d, bv, bi, a, b, two, pc, tag_of(k, exp_tk));
            end
        end
        summary();
    end

endmodule